// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from a set of device sources and one separate non-maskable source, and offers a single request line and an 8-bit vector number to a processor. Each device source has its own mask bit and a priority level set on input pins. A global enable can turn off all device requests. The non-maskable source is not affected by either.

A request is caught on the rising edge of its source line and is then pending. The processor takes the offered vector with a valid/ready handshake. `irq_o` is the valid signal and `ack_i` is the ready signal. A transfer happens in any cycle where both are high. In that cycle the winning source moves from pending to in-service. While `irq_o` is high and `ack_i` is low, the offer stays up. The offered vector may change during this wait if a request of higher rank arrives, and it is only committed at the handshake. Asserting `ack_i` while `irq_o` is low has no effect.

When a handler finishes, the processor pulses `eoi_i`. This clears one in-service entry and lowers the preemption threshold back to the level it had before. Device requests are offered only if their level is strictly above the highest level currently in service. This gives nested preemption: requests of equal or lower level wait.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset nothing is pending or in service and `irq_o` is low.
- R2: A 0-to-1 transition on a source line sets its pending bit. A line held high does not set the bit again after the request has been acknowledged.
- R3: A device source whose `mask_i` bit is 1 is never offered. Its pending bit is kept, and the source is offered once the mask bit returns to 0.
- R4: When `gen_en_i` is 0, no device source is offered, but the non-maskable source still is.
- R5: Among offerable device sources, the highest level wins. Level is a PRIO_W-bit number, and a larger number means more urgent. When levels are equal, the lowest source index wins.
- R6: A device source i is delivered as vector 32+i. The non-maskable source is delivered as vector 2. Device vectors therefore never fall below 32.
- R7: A handshake (`irq_o` and `ack_i` both high) moves the offered source from pending to in-service.
- R8: While any device is in service, a device source is offered only if its level is strictly greater than the highest in-service level.
- R9: The non-maskable source outranks every device level and is offered even while devices are in service. It is held back only while a previous non-maskable event is still in service.
- R10: `eoi_i` clears the non-maskable in-service bit if it is set. Otherwise it clears the in-service device with the highest level, picking the lowest index on a tie. With nothing in service, `eoi_i` does nothing.
- R11: `vec_o` is meaningful only while `irq_o` is high. Before the handshake it follows the current winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req_i | input | NSRC | Device request lines, edge-captured |
| nmi_req_i | input | 1 | Non-maskable request line, edge-captured |
| mask_i | input | NSRC | Per-source mask, 1 blocks the source |
| gen_en_i | input | 1 | Global enable for device sources |
| prio_i | input | NSRC*PRIO_W | Level of source i in bits [i*PRIO_W +: PRIO_W] |
| irq_o | output | 1 | Vector valid / interrupt request |
| vec_o | output | 8 | Vector number offered |
| ack_i | input | 1 | Processor ready; handshake when irq_o is also high |
| eoi_i | input | 1 | End-of-service pulse |

## Verification
The assertions check, on every cycle:
- that device vectors stay at 32 or above;
- that a disabled global enable lets only the non-maskable vector out;
- that a non-maskable event in service silences the request line;
- that each handshake adds exactly one in-service entry, while an idle acknowledge adds none;
- that an offered device outranks the in-service threshold;
- that a held line is not captured again.

Only the bench scenarios can show the things that depend on a history of events:
- which source wins a tie;
- the order in which end-of-service unwinds nested handlers;
- that a masked request survives until it is unmasked.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int VEC_W = 8;
  localparam logic [VEC_W-1:0] NMI_VECTOR = 8'd2;
  localparam int DEV_VEC_FLOOR = 32;
endpackage

// File: rtl/irqv_capture.sv
module irqv_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] line_q;
  logic [W-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      pend_q <= '0;
    end else begin
      line_q <= line_i;
      pend_q <= (pend_q & ~clr_i) | (line_i & ~line_q);
    end
  end

  assign pend_o = pend_q;

  generate
    for (genvar b = 0; b < W; b++) begin : g_chk
      // R2: a line already high one cycle earlier creates no new pending bit
      a_r2_level_no_repend : assert property (@(posedge clk) disable iff (!rst_n)
        (line_q[b] && line_i[b] && !pend_q[b]) |=> !pend_q[b]);
    end
  endgenerate
endmodule

// File: rtl/irqv_pick.sv
module irqv_pick #(
  parameter int N  = 8,
  parameter int LW = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    cand_i,
  input  logic [N*LW-1:0] lvl_i,
  output logic            any_o,
  output logic [IW-1:0]   idx_o,
  output logic [LW-1:0]   lvl_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (!any_o || lvl_i[i*LW +: LW] > lvl_o)) begin
        any_o = 1'b1;
        idx_o = IW'(i);
        lvl_o = lvl_i[i*LW +: LW];
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NSRC     = 8,
  parameter int PRIO_W   = 3,
  parameter int VEC_BASE = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        src_req_i,
  input  logic                   nmi_req_i,
  input  logic [NSRC-1:0]        mask_i,
  input  logic                   gen_en_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  output logic                   irq_o,
  output logic [7:0]             vec_o,
  input  logic                   ack_i,
  input  logic                   eoi_i
);
  import irqv_pkg::*;

  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]   pend, pend_clr, isr_q, cand, above;
  logic              nmi_pend, nmi_pend_clr, nmi_isr_q, nmi_win;
  logic              dev_any, isr_any, take;
  logic [IW-1:0]     dev_idx, isr_idx;
  logic [PRIO_W-1:0] dev_lvl, isr_lvl;

  irqv_capture #(.W(NSRC)) u_dev_cap (
    .clk(clk), .rst_n(rst_n), .line_i(src_req_i), .clr_i(pend_clr), .pend_o(pend));

  irqv_capture #(.W(1)) u_nmi_cap (
    .clk(clk), .rst_n(rst_n), .line_i(nmi_req_i), .clr_i(nmi_pend_clr), .pend_o(nmi_pend));

  // threshold: highest level among in-service devices
  irqv_pick #(.N(NSRC), .LW(PRIO_W)) u_isr_pick (
    .cand_i(isr_q), .lvl_i(prio_i), .any_o(isr_any), .idx_o(isr_idx), .lvl_o(isr_lvl));

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_thr
      assign above[s] = !isr_any || (prio_i[s*PRIO_W +: PRIO_W] > isr_lvl);
    end
  endgenerate

  assign cand = pend & ~mask_i & {NSRC{gen_en_i}} & above;

  irqv_pick #(.N(NSRC), .LW(PRIO_W)) u_dev_pick (
    .cand_i(cand), .lvl_i(prio_i), .any_o(dev_any), .idx_o(dev_idx), .lvl_o(dev_lvl));

  assign nmi_win = nmi_pend && !nmi_isr_q;
  assign irq_o   = nmi_win || (dev_any && !nmi_isr_q);
  assign vec_o   = nmi_win ? NMI_VECTOR : (8'(VEC_BASE) + 8'(dev_idx));
  assign take    = irq_o && ack_i;

  always_comb begin
    pend_clr     = '0;
    nmi_pend_clr = 1'b0;
    if (take) begin
      if (nmi_win) nmi_pend_clr = 1'b1;
      else         pend_clr[dev_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q     <= '0;
      nmi_isr_q <= 1'b0;
    end else begin
      logic [NSRC-1:0] isr_n;
      logic            nmi_n;
      isr_n = isr_q;
      nmi_n = nmi_isr_q;
      if (eoi_i) begin
        if (nmi_isr_q)    nmi_n = 1'b0;
        else if (isr_any) isr_n[isr_idx] = 1'b0;
      end
      if (take) begin
        if (nmi_win) nmi_n = 1'b1;
        else         isr_n[dev_idx] = 1'b1;
      end
      isr_q     <= isr_n;
      nmi_isr_q <= nmi_n;
    end
  end

  // R6: device vectors never enter the reserved range
  a_r6_dev_vec_floor : assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !nmi_win) |-> (vec_o >= 8'(DEV_VEC_FLOOR)));
  // R4: with global enable off only the non-maskable vector may be offered
  a_r4_gen_off_nmi_only : assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !gen_en_i) |-> (vec_o == NMI_VECTOR));
  // R9: non-maskable in service blocks the request line
  a_r9_nmi_isr_silences : assert property (@(posedge clk) disable iff (!rst_n)
    nmi_isr_q |-> !irq_o);
  // R7: a device handshake adds exactly one in-service entry
  a_r7_take_adds_one : assert property (@(posedge clk) disable iff (!rst_n)
    (take && !nmi_win && !eoi_i) |=> ($countones(isr_q) == $countones($past(isr_q)) + 1));
  // R7: acknowledge without a request changes nothing
  a_r7_idle_ack : assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o && !eoi_i) |=> ($stable(isr_q) && $stable(nmi_isr_q)));
  // R8: an offered device outranks the in-service threshold
  a_r8_preempt_only_higher : assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !nmi_win && isr_any) |-> (dev_lvl > isr_lvl));
endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
  localparam int NSRC = 8;
  localparam int PW   = 3;
  localparam int NROW = 28;
  // row: {op[3], data[8], req[4], exp_irq[1], exp_vec[8]}
  // op: 0 raise lines, 1 ack, 2 eoi, 3 set mask, 4 set global enable, 5 nmi
  localparam logic [23:0] ROWS [NROW] = '{
    {3'd0, 8'h01, 4'd2,  1'b1, 8'd32}, // R2 capture
    {3'd0, 8'h02, 4'd11, 1'b1, 8'd33}, // R11 offer changes before ack, R5
    {3'd1, 8'h00, 4'd7,  1'b0, 8'd0},  // R7
    {3'd0, 8'h08, 4'd8,  1'b1, 8'd35}, // R8 preempt
    {3'd1, 8'h00, 4'd8,  1'b0, 8'd0},  // R8
    {3'd0, 8'h80, 4'd8,  1'b0, 8'd0},  // R8 equal waits
    {3'd2, 8'h00, 4'd10, 1'b1, 8'd39}, // R10 threshold restored
    {3'd3, 8'h80, 4'd3,  1'b0, 8'd0},  // R3 mask
    {3'd2, 8'h00, 4'd10, 1'b1, 8'd32}, // R10
    {3'd4, 8'h00, 4'd4,  1'b0, 8'd0},  // R4
    {3'd5, 8'h00, 4'd4,  1'b1, 8'd2},  // R4 nmi unaffected, R6
    {3'd1, 8'h00, 4'd9,  1'b0, 8'd0},  // R9
    {3'd4, 8'h01, 4'd9,  1'b0, 8'd0},  // R9 nmi in service blocks
    {3'd2, 8'h00, 4'd10, 1'b1, 8'd32}, // R10 nmi cleared first
    {3'd3, 8'h00, 4'd3,  1'b1, 8'd39}, // R3 unmask releases
    {3'd0, 8'h10, 4'd5,  1'b1, 8'd39}, // R5
    {3'd1, 8'h00, 4'd7,  1'b0, 8'd0},  // R7
    {3'd2, 8'h00, 4'd5,  1'b1, 8'd32}, // R5 tie lowest index
    {3'd1, 8'h00, 4'd8,  1'b0, 8'd0},  // R8
    {3'd2, 8'h00, 4'd5,  1'b1, 8'd36}, // R5
    {3'd1, 8'h00, 4'd7,  1'b0, 8'd0},  // R7
    {3'd2, 8'h00, 4'd10, 1'b0, 8'd0},  // R10
    {3'd0, 8'h04, 4'd6,  1'b1, 8'd34}, // R6
    {3'd1, 8'h00, 4'd7,  1'b0, 8'd0},  // R7
    {3'd5, 8'h00, 4'd9,  1'b1, 8'd2},  // R9 over in-service device
    {3'd1, 8'h00, 4'd9,  1'b0, 8'd0},  // R9
    {3'd2, 8'h00, 4'd10, 1'b0, 8'd0},  // R10
    {3'd2, 8'h00, 4'd10, 1'b0, 8'd0}   // R10
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] src = '0, mask = '0;
  logic nmi = 1'b0, gen_en = 1'b1, ack = 1'b0, eoi = 1'b0;
  logic [NSRC*PW-1:0] prio = {3'd3,3'd2,3'd1,3'd0,3'd3,3'd2,3'd1,3'd0};
  logic irq;
  logic [7:0] vec;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl #(.NSRC(NSRC), .PRIO_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_req_i(src), .nmi_req_i(nmi), .mask_i(mask),
    .gen_en_i(gen_en), .prio_i(prio), .irq_o(irq), .vec_o(vec), .ack_i(ack), .eoi_i(eoi));

  task automatic check(input string tag, input logic e_irq, input logic [7:0] e_vec);
    n_chk++;
    if (irq !== e_irq || (e_irq && vec !== e_vec)) begin
      n_bad++;
      $display("FAIL %s: irq=%0b vec=%0d expected irq=%0b vec=%0d", tag, irq, vec, e_irq, e_vec);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    src = '0; nmi = 1'b0; ack = 1'b0; eoi = 1'b0;
  endtask

  initial begin
    #200000ns;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 1'b0, 8'd0);

    for (int r = 0; r < NROW; r++) begin
      logic [2:0] op;
      logic [7:0] d;
      op = ROWS[r][23:21];
      d  = ROWS[r][20:13];
      case (op)
        3'd0: src = d;
        3'd1: ack = 1'b1;
        3'd2: eoi = 1'b1;
        3'd3: mask = d;
        3'd4: gen_en = d[0];
        default: nmi = 1'b1;
      endcase
      step();
      check($sformatf("row %0d R%0d", r, ROWS[r][12:9]), ROWS[r][8], ROWS[r][7:0]);
    end

    // R7: acknowledge with nothing offered is ignored
    ack = 1'b1; step();
    check("R7 idle ack", 1'b0, 8'd0);
    src = 8'h01; step();
    check("R7 no phantom in-service", 1'b1, 8'd32);
    ack = 1'b1; step(); eoi = 1'b1; step();

    // R2: held line is not captured again
    src = 8'h20; @(posedge clk); @(negedge clk);
    check("R2 held line captured once", 1'b1, 8'd37);
    ack = 1'b1; @(posedge clk); @(negedge clk); ack = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 held line no repend", 1'b0, 8'd0);
    eoi = 1'b1; @(posedge clk); @(negedge clk); eoi = 1'b0;
    check("R2 held line after eoi", 1'b0, 8'd0);
    src = '0; @(negedge clk);

    // R10: eoi with nothing in service leaves a new request intact
    eoi = 1'b1; step();
    src = 8'h01; step();
    check("R10 empty eoi harmless", 1'b1, 8'd32);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule